// File: doc/BRIEF.md
# Configurable Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It reads a first table of branch history shift registers. That history, mixed with program counter bits, selects an entry in a second table of 2-bit saturating counters. The top bit of the selected counter is the guess. Elaboration parameters set four things: how many history registers there are, how wide each one is, how many counters there are, and whether the counter index is formed by XOR or by concatenation. With these the one structure can act as global or per-address history, over either a shared or an address-extended counter table, including the XOR-indexed global form.

A lookup port takes a program counter and returns the guess in the same cycle. An update port takes the program counter of a resolved branch and its real outcome, and trains the state on the next clock edge. A mode input chooses among four predictors at run time:
- always not-taken
- always taken
- counters indexed by the program counter alone
- the full two-level scheme

Top module: `bp_two_level`

## Requirements
- R1: With `mode` = 0 the output `lk_taken` is 0, and with `mode` = 1 it is 1. This holds for any program counter and any trained state.
- R2: With `mode` = 2 (PC-only) or `mode` = 3 (two-level), `lk_taken` equals bit 1 of the selected counter. In mode 2 the counter index is `PC[IDX_W+1:2]`, where IDX_W = log2(PHT_ENTRIES).
- R3: A training update increments the selected counter on a taken outcome and decrements it on a not-taken outcome. The counter saturates at 3 and at 0.
- R4: Every training update shifts the selected history register left by one and puts the outcome in bit 0. The register is selected by `PC[SEL_W+1:2]`, with SEL_W = log2(HIST_REGS). When HIST_REGS = 1 the single register is always used.
- R5: In mode 3 the counter index is built from the history. When XOR is disabled it is `{PC[IDX_W-HIST_W+1:2], history}`, or the low IDX_W history bits if HIST_W >= IDX_W. When XOR is enabled it is `PC[IDX_W+1:2] ^ history`.
- R6: A lookup and an update that hit the same counter in the same cycle make the lookup return the counter value from before that update. The change is visible from the next cycle.
- R7: An update while `mode` is 0 or 1 changes no counter and no history register.
- R8: Asserting `rst_n` low sets every counter to 01 and clears every history register. Release is synchronised over two clock edges. Right after reset, mode 3 predicts not-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 not-taken, 1 taken, 2 PC-indexed counters, 3 two-level |
| lk_pc | input | PC_W | Program counter to predict |
| lk_taken | output | 1 | Predicted direction, combinational from lk_pc |
| up_en | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | Program counter of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The hardest case to reach from the ports is one where a history register has been shaped by a particular run of outcomes, and that shaped history then points a later lookup at a specific counter. The stimulus does this in three steps. It trains several program counters that map to different history registers, interleaving their updates. It then sends lookups and updates to the same counter in the same cycle, to expose the ordering between the two. Two instances run the same stimulus, one with per-address history and concatenated index and one with global history and XOR index, against a reference model built from the requirements.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    BP_NOT_TAKEN = 2'd0,
    BP_TAKEN     = 2'd1,
    BP_BIMODAL   = 2'd2,
    BP_TWO_LEVEL = 2'd3
  } bp_mode_e;

  localparam logic [1:0] CTR_RESET = 2'b01;
endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int REGS   = 4,
  parameter int HIST_W = 4,
  localparam int SEL_W = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_en,
  input  logic              wr_bit,
  output logic [HIST_W-1:0] rd_hist,
  output logic [HIST_W-1:0] wr_hist
);
  logic [HIST_W-1:0] hist_q [REGS];
  logic [HIST_W-1:0] hist_d;

  generate
    if (REGS == 1) begin : g_single
      assign rd_hist = hist_q[0];
      assign wr_hist = hist_q[0];
    end else begin : g_multi
      assign rd_hist = hist_q[rd_sel];
      assign wr_hist = hist_q[wr_sel];
    end
  endgenerate

  always_comb begin
    hist_d = {wr_hist[HIST_W-2:0], wr_bit};
  end

  for (genvar g = 0; g < REGS; g++) begin : g_reg
    logic reg_en;
    assign reg_en = wr_en && ((REGS == 1) || (wr_sel == SEL_W'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q[g] <= '0;
      end else if (reg_en) begin
        hist_q[g] <= hist_d;
      end
    end
  end
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 4,
  parameter int IDX_W   = 6,
  parameter bit USE_XOR = 1'b0
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  input  logic              two_level,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] pc_bits;
  logic [IDX_W-1:0] lvl_idx;

  assign pc_bits = pc[IDX_W+1:2];

  generate
    if (USE_XOR) begin : g_xor
      assign lvl_idx = pc_bits ^ IDX_W'(hist);
    end else if (IDX_W > HIST_W) begin : g_cat
      assign lvl_idx = {pc_bits[IDX_W-HIST_W-1:0], hist};
    end else begin : g_hist
      assign lvl_idx = hist[IDX_W-1:0];
    end
  endgenerate

  always_comb begin
    idx = two_level ? lvl_idx : pc_bits;
  end
endmodule

// File: rtl/bp_pht.sv
module bp_pht #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             wr_en,
  input  logic             wr_taken,
  output logic [1:0]       lk_ctr,
  output logic [1:0]       up_ctr
);
  import bp_pkg::*;

  logic [1:0] ctr_q [ENTRIES];
  logic [1:0] ctr_d;

  assign lk_ctr = ctr_q[lk_idx];
  assign up_ctr = ctr_q[up_idx];

  always_comb begin
    ctr_d = up_ctr;
    if (wr_taken) begin
      if (up_ctr != 2'b11) ctr_d = up_ctr + 2'b01;
    end else begin
      if (up_ctr != 2'b00) ctr_d = up_ctr - 2'b01;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ctr
    logic ctr_en;
    assign ctr_en = wr_en && (up_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctr_q[e] <= CTR_RESET;
      end else if (ctr_en) begin
        ctr_q[e] <= ctr_d;
      end
    end
  end
endmodule

// File: rtl/bp_two_level.sv
module bp_two_level #(
  parameter int PC_W        = 32,
  parameter int HIST_REGS   = 4,
  parameter int HIST_W      = 4,
  parameter int PHT_ENTRIES = 64,
  parameter bit USE_XOR     = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_en,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  import bp_pkg::*;

  localparam int PHT_IDX_W = $clog2(PHT_ENTRIES);
  localparam int SEL_W     = (HIST_REGS > 1) ? $clog2(HIST_REGS) : 1;

  logic [1:0]           rst_pipe_q;
  logic                 rst_sync_n;
  bp_mode_e             mode_e;
  logic                 two_level;
  logic                 train;
  logic [SEL_W-1:0]     lk_sel;
  logic [SEL_W-1:0]     up_sel;
  logic [HIST_W-1:0]    lk_hist;
  logic [HIST_W-1:0]    up_hist;
  logic [PHT_IDX_W-1:0] lk_idx;
  logic [PHT_IDX_W-1:0] up_idx;
  logic [1:0]           lk_ctr;
  logic [1:0]           up_ctr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign mode_e    = bp_mode_e'(mode);
  assign two_level = (mode_e == BP_TWO_LEVEL);
  assign train     = up_en && ((mode_e == BP_BIMODAL) || (mode_e == BP_TWO_LEVEL));

  generate
    if (HIST_REGS > 1) begin : g_sel
      assign lk_sel = lk_pc[SEL_W+1:2];
      assign up_sel = up_pc[SEL_W+1:2];
    end else begin : g_nosel
      assign lk_sel = '0;
      assign up_sel = '0;
    end
  endgenerate

  bp_hist_table #(.REGS(HIST_REGS), .HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_sync_n), .rd_sel(lk_sel), .wr_sel(up_sel),
    .wr_en(train), .wr_bit(up_taken), .rd_hist(lk_hist), .wr_hist(up_hist)
  );

  bp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(PHT_IDX_W), .USE_XOR(USE_XOR)) u_lk_index (
    .pc(lk_pc), .hist(lk_hist), .two_level(two_level), .idx(lk_idx)
  );

  bp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(PHT_IDX_W), .USE_XOR(USE_XOR)) u_up_index (
    .pc(up_pc), .hist(up_hist), .two_level(two_level), .idx(up_idx)
  );

  bp_pht #(.ENTRIES(PHT_ENTRIES)) u_pht (
    .clk(clk), .rst_n(rst_sync_n), .lk_idx(lk_idx), .up_idx(up_idx),
    .wr_en(train), .wr_taken(up_taken), .lk_ctr(lk_ctr), .up_ctr(up_ctr)
  );

  always_comb begin
    case (mode_e)
      BP_NOT_TAKEN: lk_taken = 1'b0;
      BP_TAKEN:     lk_taken = 1'b1;
      default:      lk_taken = lk_ctr[1];
    endcase
  end
endmodule

// File: rtl/bp_two_level_chk.sv
module bp_two_level_chk #(
  parameter int HIST_W = 4,
  parameter int IDX_W  = 6,
  parameter int SEL_W  = 2
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [1:0]       mode,
  input logic             lk_taken,
  input logic [1:0]       lk_ctr,
  input logic [IDX_W-1:0] lk_idx,
  input logic             up_en,
  input logic             up_taken,
  input logic [SEL_W-1:0] up_sel,
  input logic [IDX_W-1:0] up_idx,
  input logic [1:0]       up_ctr,
  input logic [HIST_W-1:0] up_hist
);
  logic trains;
  assign trains = up_en && mode[1];

  p_static_nt_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 2'd0) |-> !lk_taken);
  p_static_t_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 2'd1) |-> lk_taken);

  p_pred_msb_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode[1] |-> (lk_taken == lk_ctr[1]));

  p_inc_dec_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(trains) && (up_idx == $past(up_idx))) |->
      (up_ctr == ($past(up_taken) ? (($past(up_ctr) == 2'b11) ? 2'b11 : $past(up_ctr) + 2'b01)
                                  : (($past(up_ctr) == 2'b00) ? 2'b00 : $past(up_ctr) - 2'b01))));

  p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(trains) && (up_sel == $past(up_sel))) |->
      (up_hist == {$past(up_hist[HIST_W-2:0]), $past(up_taken)}));

  p_lookup_old_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trains && (lk_idx == up_idx)) |-> (lk_ctr == up_ctr));

  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(up_en && !mode[1]) && (up_idx == $past(up_idx)) && (up_sel == $past(up_sel))) |->
      ((up_ctr == $past(up_ctr)) && (up_hist == $past(up_hist))));
endmodule

bind bp_two_level bp_two_level_chk #(.HIST_W(HIST_W), .IDX_W(PHT_IDX_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .mode(mode), .lk_taken(lk_taken), .lk_ctr(lk_ctr),
  .lk_idx(lk_idx), .up_en(up_en), .up_taken(up_taken), .up_sel(up_sel), .up_idx(up_idx),
  .up_ctr(up_ctr), .up_hist(up_hist)
);

// File: tb/bp_two_level_bench.sv
`timescale 1ns/1ps
module bp_two_level_bench;
  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic [31:0] lk_pc;
  logic        up_en;
  logic [31:0] up_pc;
  logic        up_taken;
  logic        lk_a;
  logic        lk_b;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  typedef struct {
    bit    exp_a;
    bit    exp_b;
    string tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  bit [1:0] ctr_a [64];
  bit [1:0] ctr_b [64];
  bit [3:0] hist_a [4];
  bit [5:0] hist_b;

  bp_two_level #(.PC_W(32), .HIST_REGS(4), .HIST_W(4), .PHT_ENTRIES(64), .USE_XOR(1'b0)) u_bp_two_level (
    .clk(clk), .rst_n(rst_n), .mode(mode), .lk_pc(lk_pc), .lk_taken(lk_a),
    .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken)
  );

  bp_two_level #(.PC_W(32), .HIST_REGS(1), .HIST_W(6), .PHT_ENTRIES(64), .USE_XOR(1'b1)) u_bp_two_level_gs (
    .clk(clk), .rst_n(rst_n), .mode(mode), .lk_pc(lk_pc), .lk_taken(lk_b),
    .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int idx_a(bit [31:0] pc, bit two);
    bit [29:0] w = pc[31:2];
    if (two) return int'({w[1:0], hist_a[w[1:0]]});
    return int'(w[5:0]);
  endfunction

  function automatic int idx_b(bit [31:0] pc, bit two);
    bit [29:0] w = pc[31:2];
    if (two) return int'(w[5:0] ^ hist_b);
    return int'(w[5:0]);
  endfunction

  function automatic bit [1:0] sat(bit [1:0] c, bit t);
    if (t) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin ctr_a[i] = 2'b01; ctr_b[i] = 2'b01; end
    for (int i = 0; i < 4; i++) hist_a[i] = '0;
    hist_b = '0;
  endtask

  task automatic step(bit [1:0] m, bit [31:0] lpc, bit ue, bit [31:0] upc, bit ut, string tag);
    sb_item_t it;
    int ia, ib;
    @(posedge clk); #1;
    mode = m; lk_pc = lpc; up_en = ue; up_pc = upc; up_taken = ut;
    if (m == 2'd0) begin it.exp_a = 1'b0; it.exp_b = 1'b0; end
    else if (m == 2'd1) begin it.exp_a = 1'b1; it.exp_b = 1'b1; end
    else begin
      it.exp_a = ctr_a[idx_a(lpc, m == 2'd3)][1];
      it.exp_b = ctr_b[idx_b(lpc, m == 2'd3)][1];
    end
    it.tag = tag;
    sb_q.push_back(it);
    if (ue && m[1]) begin
      ia = idx_a(upc, m == 2'd3);
      ib = idx_b(upc, m == 2'd3);
      ctr_a[ia] = sat(ctr_a[ia], ut);
      ctr_b[ib] = sat(ctr_b[ib], ut);
      hist_a[upc[3:2]] = {hist_a[upc[3:2]][2:0], ut};
      hist_b = {hist_b[4:0], ut};
    end
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      checks += 2;
      if (lk_a !== it.exp_a) begin
        errors++;
        $display("FAIL %s inst_a pc=%h mode=%0d actual=%b expected=%b", it.tag, lk_pc, mode, lk_a, it.exp_a);
      end
      if (lk_b !== it.exp_b) begin
        errors++;
        $display("FAIL %s inst_b pc=%h mode=%0d actual=%b expected=%b", it.tag, lk_pc, mode, lk_b, it.exp_b);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'd3; lk_pc = '0; up_en = 1'b0; up_pc = '0; up_taken = 1'b0;
    model_reset();
    #20;
    checks++;
    if (lk_a !== 1'b0 || lk_b !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset prediction actual=%b%b expected=00", lk_a, lk_b);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    step(2'd3, 32'h200, 0, 0, 0, "R8");
    step(2'd2, 32'h204, 0, 0, 0, "R8");

    // R1 static modes under various PCs
    for (int i = 0; i < 4; i++) step(2'd0, 32'h1000 + 4 * i, 0, 0, 0, "R1");
    for (int i = 0; i < 4; i++) step(2'd1, 32'h2000 + 4 * i, 0, 0, 0, "R1");

    // R7 updates in static modes must not train
    for (int i = 0; i < 4; i++) step(2'd1, 32'h40, 1, 32'h40, 1, "R7");
    for (int i = 0; i < 4; i++) step(2'd0, 32'h44, 1, 32'h44, 1, "R7");
    step(2'd2, 32'h40, 0, 0, 0, "R7");
    step(2'd2, 32'h44, 0, 0, 0, "R7");
    step(2'd3, 32'h40, 0, 0, 0, "R7");

    // R2/R3 PC-indexed counters, saturation both ways
    for (int i = 0; i < 5; i++) step(2'd2, 32'h40, 1, 32'h40, 1, "R3");
    step(2'd2, 32'h40, 1, 32'h40, 0, "R3");
    step(2'd2, 32'h40, 0, 0, 0, "R3");
    step(2'd2, 32'h40, 1, 32'h40, 0, "R3");
    step(2'd2, 32'h40, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(2'd2, 32'h48, 1, 32'h48, 0, "R3");
    step(2'd2, 32'h48, 1, 32'h48, 1, "R3");
    step(2'd2, 32'h48, 0, 0, 0, "R3");

    // R6 same-cycle lookup and update of one entry
    step(2'd2, 32'h80, 1, 32'h80, 1, "R6");
    step(2'd2, 32'h80, 1, 32'h80, 1, "R6");
    step(2'd2, 32'h80, 0, 0, 0, "R6");

    // R4/R5 per-address history with interleaved PCs
    for (int i = 0; i < 8; i++) begin
      step(2'd3, 32'h100, 1, 32'h100, 1, "R4");
      step(2'd3, 32'h104, 1, 32'h104, i[0], "R4");
    end
    for (int i = 0; i < 6; i++) step(2'd3, 32'h10c, 1, 32'h10c, (i % 3) != 0, "R5");
    step(2'd3, 32'h100, 0, 0, 0, "R5");
    step(2'd3, 32'h104, 0, 0, 0, "R5");
    step(2'd3, 32'h10c, 0, 0, 0, "R5");

    // mixed random traffic across all modes
    for (int i = 0; i < 3000; i++) begin
      bit [1:0] m;
      bit [31:0] a, b;
      m = ($urandom_range(0, 9) < 8) ? 2'(2 + $urandom_range(0, 1)) : 2'($urandom_range(0, 1));
      a = {24'h0, 6'($urandom_range(0, 63)), 2'b00};
      b = ($urandom_range(0, 3) == 0) ? a : {24'h0, 6'($urandom_range(0, 63)), 2'b00};
      step(m, a, 1'($urandom_range(0, 1)), b, 1'($urandom_range(0, 1)), "R5");
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule